// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for a four-beat burst inside a synchronous memory. On each rising clock edge it does one of three things. It can capture a fresh start address from the external address bus, advance an internal beat counter, or hold. Either of two active-low load strobes captures a new address. An active-low advance input steps the burst to its next beat.

The low two bits of the address follow one of two orders, chosen by an active-low mode input. In linear order the low bits count upward from the start address and wrap modulo four. In interleaved order the low bits are the start address XOR-ed with a beat count that runs 0, 1, 2, 3. The upper address bits are captured on a load and then held for the whole burst.

The block has no data stream, so every pin is a plain control or address signal with no handshake. A load may be issued on every cycle, one after another, with no idle cycle between loads. The order input is meant to be static. Because it is applied after the registers, a change to it takes effect on the output at once.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `burst_lo = 0` and `addr_hi = 0`, and the beat count restarts at 0.
- R2: A rising edge with `load_a_n` low, `load_b_n` low, or both low loads a new address. After that edge, `burst_lo` equals `addr_in[1:0]` and `addr_hi` equals `addr_in[ADDR_W-1:2]`, and the beat count restarts at 0.
- R3: With `lin_order_n = 0` (linear order), the output after k advances since the last load is `burst_lo = (start + k) mod 4`.
- R4: With `lin_order_n = 1` (interleaved order, also the default level), the output after k advances since the last load is `burst_lo = start XOR (k mod 4)`.
- R5: A rising edge with both strobes high and `adv_n` high leaves `burst_lo` and `addr_hi` unchanged.
- R6: A strobe takes priority over `adv_n` low in the same cycle. Loads on consecutive cycles each take effect on the following cycle.
- R7: `addr_hi` changes only on an edge that loads a new address. Advances and holds leave it unchanged.
- R8: After four advances from a load, `burst_lo` is back at the start address in both orders.
- R9: The order is applied to the registered start address and beat count combinationally. Changing `lin_order_n` with no clock edge changes `burst_lo` to the value the new order gives for the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_a_n | input | 1 | First address-load strobe, active low |
| load_b_n | input | 1 | Second address-load strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| lin_order_n | input | 1 | Order select: 0 gives linear order, 1 gives interleaved order |
| addr_in | input | ADDR_W | External address; bits [1:0] give the burst start |
| burst_lo | output | 2 | Current low burst address bits |
| addr_hi | output | ADDR_W-2 | Upper address held since the last load |

## Verification
Every start value is loaded in both orders, through each strobe separately and through both together. Each load is followed by four advances and a fifth beat, which checks the full sequence and the wrap back to the start. This separates an adder from an XOR mapping: the two orders agree for starts 0 and 2 but differ for starts 1 and 3.

Hold cycles are placed between advances to show that the count and the upper bits stay put. Strobes are raised together with an advance to show that the load wins. Loads on every cycle with changing address values show that back-to-back loads work. A mode flip with no clock edge between shows that the order is applied after the registers.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Burst ordering selected by the active-low order pin.
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // Per-edge action of the sequencer.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } seq_act_e;
endpackage

// File: rtl/burst_seq_decode.sv
module burst_seq_decode
  import burst_seq_pkg::*;
(
  input  logic     load_a_n,
  input  logic     load_b_n,
  input  logic     adv_n,
  output seq_act_e act
);
  // A strobe outranks the advance enable.
  always_comb begin
    if (!load_a_n || !load_b_n) act = ACT_LOAD;
    else if (!adv_n)            act = ACT_STEP;
    else                        act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_count_reg.sv
module burst_count_reg
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_act_e           act,
  input  logic [BURST_W-1:0] start_in,
  output logic [BURST_W-1:0] start_q,
  output logic [BURST_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          start_q <= start_in;
          count_q <= '0;
        end
        ACT_STEP: count_q <= count_q + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  burst_order_e       order,
  input  logic [BURST_W-1:0] start_q,
  input  logic [BURST_W-1:0] count_q,
  output logic [BURST_W-1:0] addr_lo
);
  logic [BURST_W-1:0] lin_addr;
  logic [BURST_W-1:0] ilv_addr;

  assign lin_addr = start_q + count_q;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv_bit
    assign ilv_addr[b] = start_q[b] ^ count_q[b];
  end

  assign addr_lo = (order == ORDER_LINEAR) ? lin_addr : ilv_addr;
endmodule

// File: rtl/upper_addr_reg.sv
module upper_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_act_e        act,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)               hi_q <= '0;
    else if (act == ACT_LOAD) hi_q <= hi_in;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_a_n,
  input  logic                      load_b_n,
  input  logic                      adv_n,
  input  logic                      lin_order_n,
  input  logic [ADDR_W-1:0]         addr_in,
  output logic [BURST_W-1:0]        burst_lo,
  output logic [ADDR_W-BURST_W-1:0] addr_hi
);
  localparam int HI_W = ADDR_W - BURST_W;

  seq_act_e           act;
  burst_order_e       order;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] count_q;

  assign order = burst_order_e'(lin_order_n);

  burst_seq_decode u_decode (
    .load_a_n (load_a_n),
    .load_b_n (load_b_n),
    .adv_n    (adv_n),
    .act      (act)
  );

  burst_count_reg #(.BURST_W(BURST_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .start_in (addr_in[BURST_W-1:0]),
    .start_q  (start_q),
    .count_q  (count_q)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .order   (order),
    .start_q (start_q),
    .count_q (count_q),
    .addr_lo (burst_lo)
  );

  upper_addr_reg #(.HI_W(HI_W)) u_upper (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .hi_in (addr_in[ADDR_W-1:BURST_W]),
    .hi_q  (addr_hi)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 18,
  parameter int BURST_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_a_n,
  input logic                      load_b_n,
  input logic                      adv_n,
  input logic                      lin_order_n,
  input logic [ADDR_W-1:0]         addr_in,
  input logic [BURST_W-1:0]        burst_lo,
  input logic [ADDR_W-BURST_W-1:0] addr_hi
);
  logic strobe;
  logic rst_seen_q;
  assign strobe = !load_a_n || !load_b_n;

  // R1: the edge after a sampled reset yields zero outputs.
  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
    if (rst_seen_q === 1'b1) begin
      a_r1_reset_zero: assert (burst_lo == '0 && addr_hi == '0)
        else $error("R1 reset state wrong");
    end
  end

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (burst_lo == $past(addr_in[BURST_W-1:0]) &&
                addr_hi == $past(addr_in[ADDR_W-1:BURST_W])));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !adv_n && !lin_order_n) |=>
      (!lin_order_n -> burst_lo == BURST_W'($past(burst_lo) + 1'b1)));

  a_r4_interleave_lsb_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !adv_n && lin_order_n) |=>
      (lin_order_n -> burst_lo[0] != $past(burst_lo[0])));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && adv_n) |=> ($stable(lin_order_n) -> $stable(burst_lo)));

  a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(addr_hi));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int ADDR_W = 18;
  localparam int HI_W   = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_a_n = 1'b1;
  logic              load_b_n = 1'b1;
  logic              adv_n = 1'b1;
  logic              lin_order_n = 1'b1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [1:0]        burst_lo;
  logic [HI_W-1:0]   addr_hi;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BURST_W(2)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load_a_n(load_a_n), .load_b_n(load_b_n),
    .adv_n(adv_n), .lin_order_n(lin_order_n), .addr_in(addr_in),
    .burst_lo(burst_lo), .addr_hi(addr_hi)
  );

  function automatic logic [1:0] exp_lo(input logic lin_n, input logic [1:0] s, input int k);
    return lin_n ? (s ^ 2'(k)) : 2'(int'(s) + k);
  endfunction

  task automatic chk(input string req, input logic [1:0] lo_e, input logic [HI_W-1:0] hi_e);
    n_vec++;
    if (burst_lo !== lo_e || addr_hi !== hi_e) begin
      n_bad++;
      $display("FAIL %s: lo=%0d hi=%h expected lo=%0d hi=%h", req, burst_lo, addr_hi, lo_e, hi_e);
    end
  endtask

  // One clock edge; inputs are changed and outputs sampled 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_in(input logic a_n, input logic b_n, input logic v_n, input logic [ADDR_W-1:0] a);
    load_a_n = a_n; load_b_n = b_n; adv_n = v_n; addr_in = a;
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [HI_W-1:0]   hi;
    tick(); tick();
    chk("R1 reset", 2'd0, '0);
    rst_n = 1'b1;

    // Exhaustive sweep: both orders, all starts, every strobe combination.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int st = 1; st < 4; st++) begin
          lin_order_n = 1'(m);
          hi = HI_W'(32'h9A5C3 * (s + 1) + st * 7 + m);
          a = {hi, 2'(s)};
          set_in(!st[0], !st[1], 1'b1, a);
          tick();
          chk("R2 load", 2'(s), hi);
          set_in(1'b1, 1'b1, 1'b0, ~a);
          for (int k = 1; k <= 5; k++) begin
            tick();
            chk(m ? "R4 interleaved beat" : "R3 linear beat", exp_lo(1'(m), 2'(s), k), hi);
            if (k == 4) chk("R8 wrap to start", 2'(s), hi);
            if (k == 2) begin
              adv_n = 1'b1;
              tick(); tick();
              chk("R5 hold", exp_lo(1'(m), 2'(s), 2), hi);
              chk("R7 upper unchanged", exp_lo(1'(m), 2'(s), 2), hi);
              adv_n = 1'b0;
            end
          end
          adv_n = 1'b1;
        end
      end
    end

    // Strobe beats advance; back-to-back loads every cycle.
    for (int i = 0; i < 8; i++) begin
      hi = HI_W'(16'h1111 * i + 5);
      set_in(i[0], !i[0], 1'b0, {hi, 2'(3 - (i % 4))});
      tick();
      chk("R6 priority/back-to-back", 2'(3 - (i % 4)), hi);
    end
    set_in(1'b1, 1'b1, 1'b0, '0);
    tick();
    chk("R6 advance after loads", exp_lo(lin_order_n, 2'd0, 1), HI_W'(16'h1111 * 7 + 5));

    // Mode flip without a clock edge: start 1, one beat.
    set_in(1'b0, 1'b1, 1'b1, {HI_W'(3), 2'd1});
    tick();
    set_in(1'b1, 1'b1, 1'b0, '0);
    lin_order_n = 1'b0;
    tick();
    adv_n = 1'b1;
    chk("R9 linear view", 2'd2, HI_W'(3));
    lin_order_n = 1'b1;
    #1;
    chk("R9 interleaved view", 2'd0, HI_W'(3));

    // Reset mid-burst.
    rst_n = 1'b0;
    tick();
    chk("R1 reset mid-burst", 2'd0, '0);
    rst_n = 1'b1;
    adv_n = 1'b0;
    tick();
    chk("R1 count restarted", 2'd1, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule